// File: doc/BRIEF.md
# Inbound Address Window Filter

This block sits between the link side of a PCIe endpoint path and the local memory bus. For every inbound memory request address it decides, one clock later, whether the request may go on to local memory or must be refused. The decision rests on a small set of address windows. Each window has a lower bound and an upper bound, both inclusive, and any byte address is a legal bound. One mode bit applies to all windows. When it is set, a request passes only if it lands inside a window. When it is clear, a request passes only if it lands outside every window.

Software programs the windows through a plain register port: a write strobe with an offset and data, and a combinational read-back selected by the same offset. To switch a window off, software programs its lower bound above its upper bound. The reset pattern does exactly this. At reset the mode bit is set, so no request passes until software opens a window. The filter makes only the accept or refuse decision. It moves no data and translates no addresses.

Top module: `ibw_filter_top`

## Requirements
- R1: After reset every window lower bound reads 0xFFFFFFFF, every upper bound reads 0x00000000, the control register reads 0x00000002 (mode bit 1 set), and every request is refused.
- R2: Window i lower bound sits at offset 0x964 + 0x10*i and its upper bound at 0x968 + 0x10*i. The control register sits at 0x900 and stores only bit 1. Each register reads back what was last written to it, and the unstored control bits read 0.
- R3: An address hits a window when lower <= address <= upper. Both bounds count as inside.
- R4: With control bit 1 = 1 (pass-inside), a request passes if it hits at least one window.
- R5: With control bit 1 = 0 (pass-outside), a request passes only if it hits no window.
- R6: A window whose lower bound is above its upper bound hits no address, including 0x00000000 and 0xFFFFFFFF.
- R7: dec_valid equals req_valid from the cycle before. When dec_valid is 1, exactly one of dec_pass and block_hit is 1. When dec_valid is 0, both are 0.
- R8: Bounds need no alignment. Odd byte addresses and a window of a single byte work as bounds.
- R9: A write to an offset that maps to no register changes no register, and a read from such an offset returns 0.
- R10: A register write takes effect for a request presented in the cycle right after the write edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cfg_wr | input | 1 | Register write strobe |
| cfg_addr | input | 12 | Register byte offset for the write and the read |
| cfg_wdata | input | 32 | Register write data |
| cfg_rdata | output | 32 | Read data for cfg_addr (combinational) |
| req_valid | input | 1 | Inbound request present |
| req_addr | input | 32 | Inbound request byte address |
| dec_valid | output | 1 | A decision is presented (one cycle after req_valid) |
| dec_pass | output | 1 | Request may pass to local memory |
| block_hit | output | 1 | Request refused |

## Verification
The bench builds the block with its defaults: two windows, a 12-bit register offset, the control register at 0x900, and a window stride of 0x10. These values place both windows' bounds and the control bit at offsets the bench can reach. They also let the bench try the single-byte window, odd bounds, one window open while the other is off, and the two ends of the 32-bit address space against windows that are switched off. Because the default has exactly two windows, both the any-window-hits case and the no-window-hits case can be reached in both modes.

// File: rtl/ibw_pkg.sv
// Package ibw_pkg
// Shared word type and the window reset pattern for the inbound window filter.
// Assumes a 32-bit address and register data path.
package ibw_pkg;
    localparam int DATA_W = 32;
    typedef logic [DATA_W-1:0] word_t;
    // Reset values that leave a window switched off (lower above upper).
    localparam word_t LOWER_OFF = '1;
    localparam word_t UPPER_OFF = '0;
endpackage

// File: rtl/ibw_regfile.sv
// Module ibw_regfile
// Holds the per-window bounds and the shared mode bit. Writes are taken on the
// clock edge. Reads are combinational on the offset. Assumes offsets are
// distinct for the chosen parameters and that cfg_addr is a byte offset.
module ibw_regfile
    import ibw_pkg::*;
#(
    parameter int          NUM_WIN    = 2,
    parameter int          CFG_AW     = 12,
    parameter int unsigned CTRL_OFS   = 32'h900,
    parameter int unsigned MODE_BIT   = 1,
    parameter int unsigned WIN_BASE   = 32'h964,
    parameter int unsigned WIN_STRIDE = 32'h10,
    parameter int unsigned UPPER_GAP  = 32'h4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_wr,
    input  logic [CFG_AW-1:0] cfg_addr,
    input  word_t             cfg_wdata,
    output word_t             cfg_rdata,
    output word_t             lower_o [NUM_WIN],
    output word_t             upper_o [NUM_WIN],
    output logic              mode_incl_o
);
    localparam logic [CFG_AW-1:0] CTRL_A = CFG_AW'(CTRL_OFS);

    word_t lower_q [NUM_WIN];
    word_t upper_q [NUM_WIN];
    logic  mode_q;

    function automatic logic [CFG_AW-1:0] lower_ofs(input int unsigned idx);
        return CFG_AW'(WIN_BASE + idx * WIN_STRIDE);
    endfunction

    function automatic logic [CFG_AW-1:0] upper_ofs(input int unsigned idx);
        return CFG_AW'(WIN_BASE + idx * WIN_STRIDE + UPPER_GAP);
    endfunction

    // Register update: reset to "all windows off, pass-inside", then decoded writes.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < NUM_WIN; i++) begin
                lower_q[i] <= LOWER_OFF;
                upper_q[i] <= UPPER_OFF;
            end
            mode_q <= 1'b1;
        end else if (cfg_wr) begin
            if (cfg_addr == CTRL_A) begin
                mode_q <= cfg_wdata[MODE_BIT];
            end
            for (int i = 0; i < NUM_WIN; i++) begin
                if (cfg_addr == lower_ofs(i)) lower_q[i] <= cfg_wdata;
                if (cfg_addr == upper_ofs(i)) upper_q[i] <= cfg_wdata;
            end
        end
    end

    // Read mux: unmapped offsets return zero.
    always_comb begin
        cfg_rdata = '0;
        if (cfg_addr == CTRL_A) begin
            cfg_rdata[MODE_BIT] = mode_q;
        end
        for (int i = 0; i < NUM_WIN; i++) begin
            if (cfg_addr == lower_ofs(i)) cfg_rdata = lower_q[i];
            if (cfg_addr == upper_ofs(i)) cfg_rdata = upper_q[i];
        end
    end

    // Expose the stored state to the match logic.
    always_comb begin
        for (int i = 0; i < NUM_WIN; i++) begin
            lower_o[i] = lower_q[i];
            upper_o[i] = upper_q[i];
        end
        mode_incl_o = mode_q;
    end
endmodule

// File: rtl/ibw_window_match.sv
// Module ibw_window_match
// Compares one request address against one window's bounds. Both bounds are
// inclusive. A lower bound above the upper bound can never hit. Purely combinational.
module ibw_window_match
    import ibw_pkg::*;
(
    input  word_t lower,
    input  word_t upper,
    input  word_t addr,
    output logic  hit
);
    // Two unsigned magnitude compares; no alignment is assumed on either bound.
    always_comb begin
        hit = (addr >= lower) && (addr <= upper);
    end
endmodule

// File: rtl/ibw_decide.sv
// Module ibw_decide
// Combines the per-window hits under the mode bit and registers the outcome.
// Assumes win_hit and mode_incl are stable before the clock edge.
module ibw_decide #(
    parameter int NUM_WIN = 2
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               req_valid,
    input  logic [NUM_WIN-1:0] win_hit,
    input  logic               mode_incl,
    output logic               dec_valid,
    output logic               dec_pass,
    output logic               block_hit
);
    logic any_hit;
    logic pass_c;

    // Pass-inside takes any hit; pass-outside requires no hit.
    always_comb begin
        any_hit = |win_hit;
        pass_c  = mode_incl ? any_hit : !any_hit;
    end

    // Output stage: one register between the request and the decision.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            dec_valid <= 1'b0;
            dec_pass  <= 1'b0;
            block_hit <= 1'b0;
        end else begin
            dec_valid <= req_valid;
            dec_pass  <= req_valid && pass_c;
            block_hit <= req_valid && !pass_c;
        end
    end
endmodule

// File: rtl/ibw_filter_top.sv
// Module ibw_filter_top
// Inbound address window filter: a register file of window bounds and a mode
// bit, one comparator per window, and a registered accept/refuse decision.
// Assumes the request address is a byte address on the same clock as the port.
module ibw_filter_top
    import ibw_pkg::*;
#(
    parameter int          NUM_WIN    = 2,
    parameter int          CFG_AW     = 12,
    parameter int unsigned CTRL_OFS   = 32'h900,
    parameter int unsigned MODE_BIT   = 1,
    parameter int unsigned WIN_BASE   = 32'h964,
    parameter int unsigned WIN_STRIDE = 32'h10,
    parameter int unsigned UPPER_GAP  = 32'h4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_wr,
    input  logic [CFG_AW-1:0] cfg_addr,
    input  logic [31:0]       cfg_wdata,
    output logic [31:0]       cfg_rdata,
    input  logic              req_valid,
    input  logic [31:0]       req_addr,
    output logic              dec_valid,
    output logic              dec_pass,
    output logic              block_hit
);
    word_t              win_lower [NUM_WIN];
    word_t              win_upper [NUM_WIN];
    logic               mode_incl;
    logic [NUM_WIN-1:0] win_hit;

    ibw_regfile #(
        .NUM_WIN   (NUM_WIN),
        .CFG_AW    (CFG_AW),
        .CTRL_OFS  (CTRL_OFS),
        .MODE_BIT  (MODE_BIT),
        .WIN_BASE  (WIN_BASE),
        .WIN_STRIDE(WIN_STRIDE),
        .UPPER_GAP (UPPER_GAP)
    ) u_regs (
        .clk        (clk),
        .rst_n      (rst_n),
        .cfg_wr     (cfg_wr),
        .cfg_addr   (cfg_addr),
        .cfg_wdata  (cfg_wdata),
        .cfg_rdata  (cfg_rdata),
        .lower_o    (win_lower),
        .upper_o    (win_upper),
        .mode_incl_o(mode_incl)
    );

    // One comparator per window.
    for (genvar g = 0; g < NUM_WIN; g++) begin : g_win
        ibw_window_match u_match (
            .lower(win_lower[g]),
            .upper(win_upper[g]),
            .addr (req_addr),
            .hit  (win_hit[g])
        );
    end

    ibw_decide #(
        .NUM_WIN(NUM_WIN)
    ) u_decide (
        .clk      (clk),
        .rst_n    (rst_n),
        .req_valid(req_valid),
        .win_hit  (win_hit),
        .mode_incl(mode_incl),
        .dec_valid(dec_valid),
        .dec_pass (dec_pass),
        .block_hit(block_hit)
    );
endmodule

// File: rtl/ibw_filter_checker.sv
// Module ibw_filter_checker
// Property checks for ibw_filter_top, attached with bind. Keeps its own
// bounds compare so the registered decision is checked against stored state.
module ibw_filter_checker
    import ibw_pkg::*;
#(
    parameter int NUM_WIN = 2
) (
    input logic  clk,
    input logic  rst_n,
    input logic  req_valid,
    input word_t req_addr,
    input logic  dec_valid,
    input logic  dec_pass,
    input logic  block_hit,
    input logic  mode_incl,
    input word_t win_lower [NUM_WIN],
    input word_t win_upper [NUM_WIN],
    input word_t cfg_rdata
);
    logic ref_hit;
    logic all_off;

    // Reference hit and reset-pattern detection from the stored bounds.
    always_comb begin
        ref_hit = 1'b0;
        all_off = 1'b1;
        for (int i = 0; i < NUM_WIN; i++) begin
            if (req_addr >= win_lower[i] && req_addr <= win_upper[i]) ref_hit = 1'b1;
            if (win_lower[i] != LOWER_OFF || win_upper[i] != UPPER_OFF) all_off = 1'b0;
        end
    end

    p_reset_state_r1: assert property (@(posedge clk) disable iff (!rst_n)
        $past(!rst_n) |-> (mode_incl && all_off));

    p_decision_r5: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid |=> (dec_pass == $past(mode_incl ? ref_hit : !ref_hit)));

    p_follow_r7: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid |=> dec_valid);

    p_drop_r7: assert property (@(posedge clk) disable iff (!rst_n)
        !req_valid |=> !dec_valid);

    p_exclusive_r7: assert property (@(posedge clk) disable iff (!rst_n)
        dec_valid |-> $countones({dec_pass, block_hit}) == 1);

    p_idle_r7: assert property (@(posedge clk) disable iff (!rst_n)
        !dec_valid |-> (!dec_pass && !block_hit));

    // Read data must never be X once out of reset (R2 read mux is total).
    p_rdata_known_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !$isunknown(cfg_rdata));
endmodule

bind ibw_filter_top ibw_filter_checker #(
    .NUM_WIN(NUM_WIN)
) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .req_valid(req_valid),
    .req_addr (req_addr),
    .dec_valid(dec_valid),
    .dec_pass (dec_pass),
    .block_hit(block_hit),
    .mode_incl(mode_incl),
    .win_lower(win_lower),
    .win_upper(win_upper),
    .cfg_rdata(cfg_rdata)
);

// File: tb/ibw_filter_top_bench.sv
// Bench ibw_filter_top_bench
// Directed scenarios, one task each. Inputs change on the falling edge and
// outputs are sampled on the falling edge.
module ibw_filter_top_bench;
    localparam int CFG_AW = 12;
    localparam logic [CFG_AW-1:0] A_CTRL = 12'h900;
    localparam logic [CFG_AW-1:0] A_LO0  = 12'h964;
    localparam logic [CFG_AW-1:0] A_UP0  = 12'h968;
    localparam logic [CFG_AW-1:0] A_LO1  = 12'h974;
    localparam logic [CFG_AW-1:0] A_UP1  = 12'h978;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              cfg_wr = 1'b0;
    logic [CFG_AW-1:0] cfg_addr = '0;
    logic [31:0]       cfg_wdata = '0;
    logic [31:0]       cfg_rdata;
    logic              req_valid = 1'b0;
    logic [31:0]       req_addr = '0;
    logic              dec_valid;
    logic              dec_pass;
    logic              block_hit;

    int checks = 0;
    int errors = 0;

    always #10 clk = ~clk;

    ibw_filter_top u_ibw_filter_top (
        .clk      (clk),
        .rst_n    (rst_n),
        .cfg_wr   (cfg_wr),
        .cfg_addr (cfg_addr),
        .cfg_wdata(cfg_wdata),
        .cfg_rdata(cfg_rdata),
        .req_valid(req_valid),
        .req_addr (req_addr),
        .dec_valid(dec_valid),
        .dec_pass (dec_pass),
        .block_hit(block_hit)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [CFG_AW-1:0] a, input logic [31:0] d);
        @(negedge clk);
        cfg_wr = 1'b1; cfg_addr = a; cfg_wdata = d;
        @(negedge clk);
        cfg_wr = 1'b0;
    endtask

    task automatic rd(input string req, input logic [CFG_AW-1:0] a, input logic [31:0] exp);
        cfg_addr = a;
        #1;
        chk(req, cfg_rdata, exp);
    endtask

    // Present one request at a falling edge and check the decision one edge later.
    task automatic probe(input string req, input logic [31:0] a, input logic exp_pass);
        req_valid = 1'b1; req_addr = a;
        @(negedge clk);
        chk({req, " valid"}, {31'd0, dec_valid}, 32'd1);
        chk({req, " pass"}, {31'd0, dec_pass}, {31'd0, exp_pass});
        chk({req, " block"}, {31'd0, block_hit}, {31'd0, !exp_pass});
        req_valid = 1'b0;
    endtask

    task automatic t_reset;
        rd("R1 lower0", A_LO0, 32'hFFFF_FFFF);
        rd("R1 upper0", A_UP0, 32'h0);
        rd("R1 lower1", A_LO1, 32'hFFFF_FFFF);
        rd("R1 upper1", A_UP1, 32'h0);
        rd("R1 ctrl", A_CTRL, 32'h2);
        chk("R7 idle valid", {31'd0, dec_valid}, 32'd0);
        chk("R7 idle block", {31'd0, block_hit}, 32'd0);
        probe("R1 addr0", 32'h0, 1'b0);
        probe("R1 addrmid", 32'h8000_0000, 1'b0);
        probe("R1 addrtop", 32'hFFFF_FFFF, 1'b0);
    endtask

    task automatic t_regs;
        wr(A_CTRL, 32'hFFFF_FFFF);
        rd("R2 ctrl bit1 only", A_CTRL, 32'h2);
        wr(A_CTRL, 32'hFFFF_FFFD);
        rd("R2 ctrl clear", A_CTRL, 32'h0);
        wr(A_LO1, 32'h1234_5677);
        rd("R2 lower1", A_LO1, 32'h1234_5677);
        wr(A_UP1, 32'h89AB_CDEF);
        rd("R2 upper1", A_UP1, 32'h89AB_CDEF);
        // Unmapped offsets: neither stored nor disturbing neighbours.
        wr(12'h96C, 32'hDEAD_BEEF);
        rd("R9 read unmapped", 12'h96C, 32'h0);
        wr(12'h904, 32'h0000_0002);
        rd("R9 ctrl untouched", A_CTRL, 32'h0);
        rd("R9 lower0 untouched", A_LO0, 32'hFFFF_FFFF);
        rd("R9 lower1 untouched", A_LO1, 32'h1234_5677);
    endtask

    task automatic t_inclusive;
        wr(A_CTRL, 32'h2);
        wr(A_LO0, 32'h1000_0003);
        wr(A_UP0, 32'h1000_00FE);
        wr(A_LO1, 32'h2000_0001);
        wr(A_UP1, 32'h2000_0001);
        @(negedge clk);
        probe("R3 below lower0", 32'h1000_0002, 1'b0);
        probe("R3 at lower0", 32'h1000_0003, 1'b1);
        probe("R4 inside0", 32'h1000_0080, 1'b1);
        probe("R3 at upper0", 32'h1000_00FE, 1'b1);
        probe("R3 above upper0", 32'h1000_00FF, 1'b0);
        probe("R8 single byte", 32'h2000_0001, 1'b1);
        probe("R8 byte below", 32'h2000_0000, 1'b0);
        probe("R8 byte above", 32'h2000_0002, 1'b0);
    endtask

    task automatic t_exclusive;
        wr(A_CTRL, 32'h0);
        @(negedge clk);
        probe("R5 below lower0", 32'h1000_0002, 1'b1);
        probe("R5 at lower0", 32'h1000_0003, 1'b0);
        probe("R5 at upper0", 32'h1000_00FE, 1'b0);
        probe("R5 single byte", 32'h2000_0001, 1'b0);
        probe("R5 far away", 32'hC000_0000, 1'b1);
    endtask

    task automatic t_disable;
        wr(A_LO1, 32'hFFFF_FFFF);
        wr(A_UP1, 32'h0);
        @(negedge clk);
        probe("R6 excl old byte", 32'h2000_0001, 1'b1);
        wr(A_CTRL, 32'h2);
        @(negedge clk);
        probe("R6 incl old byte", 32'h2000_0001, 1'b0);
        probe("R6 incl win0 still", 32'h1000_0010, 1'b1);
        wr(A_LO0, 32'h0000_0100);
        wr(A_UP0, 32'h0000_00FF);
        wr(A_CTRL, 32'h0);
        @(negedge clk);
        probe("R6 excl addr0", 32'h0, 1'b1);
        probe("R6 excl addrtop", 32'hFFFF_FFFF, 1'b1);
        probe("R6 excl crossed", 32'h0000_0100, 1'b1);
    endtask

    task automatic t_timing;
        wr(A_CTRL, 32'h2);
        wr(A_LO0, 32'h4000_0000);
        wr(A_UP0, 32'h4000_0FFF);
        // Write edge immediately followed by a request: new bound applies (R10).
        @(negedge clk);
        cfg_wr = 1'b1; cfg_addr = A_UP0; cfg_wdata = 32'h4000_1FFF;
        @(negedge clk);
        cfg_wr = 1'b0;
        probe("R10 new upper", 32'h4000_1800, 1'b1);
        // Back-to-back requests with opposite outcomes (R7).
        req_valid = 1'b1; req_addr = 32'h4000_0000;
        @(negedge clk);
        chk("R7 b2b first pass", {31'd0, dec_pass}, 32'd1);
        req_addr = 32'h3FFF_FFFF;
        @(negedge clk);
        chk("R7 b2b second valid", {31'd0, dec_valid}, 32'd1);
        chk("R7 b2b second block", {31'd0, block_hit}, 32'd1);
        chk("R7 b2b second pass", {31'd0, dec_pass}, 32'd0);
        req_valid = 1'b0;
        @(negedge clk);
        chk("R7 drop valid", {31'd0, dec_valid}, 32'd0);
        chk("R7 drop pass", {31'd0, dec_pass}, 32'd0);
        chk("R7 drop block", {31'd0, block_hit}, 32'd0);
    endtask

    initial begin : watchdog
        #(20 * 100000);
        errors++;
        $display("FAIL watchdog actual=running expected=done");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin : main
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_regs();
        t_inclusive();
        t_exclusive();
        t_disable();
        t_timing();
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule